// File: doc/BRIEF.md
# Logarithmic Programmable Barrel Shifter

This block shifts a 32-bit word by any distance from 0 to 31 bit positions in a single combinational pass. Two separate control inputs pick the operation. One sets the direction, left or right. The other sets the kind of fill, logical (zeros) or arithmetic (copies of the sign). Together they give the three useful operations: left shift, logical right shift and arithmetic right shift.

The network is logarithmic. There is one two-way selection stage for each bit of the shift distance, and stage k moves the word by 2^k places when its distance bit is set. A small control decoder turns the direction input, the fill input and the sign bit of the operand into a strobe struct. Every stage uses that struct to pick its tap and its fill value. The block has no clock. It is placed on the execute path of a processor datapath, where the result is captured by whatever register follows it.

Top module: `barrel_shifter`

## Requirements
- R1: When shiftAmt is 0, dataOut equals dataIn for every combination of shiftLeft and shiftArith.
- R2: With shiftLeft=1 and shiftArith=0, dataOut equals dataIn moved up by shiftAmt positions. The vacated low bits are 0.
- R3: With shiftLeft=0 and shiftArith=0, dataOut equals dataIn moved down by shiftAmt positions. The vacated high bits are 0.
- R4: With shiftLeft=0 and shiftArith=1, dataOut equals dataIn moved down by shiftAmt positions. Every vacated high bit equals dataIn[31].
- R5: With shiftLeft=1 and shiftArith=1, dataOut is identical to the result of R2. The sign bit never enters the low bits.
- R6: Every distance from 0 to 31 is honoured, including the maximum of 31. At 31, a right shift leaves only the old bit 31 in bit 0.
- R7: Distance bit k (k = 0..4) moves the word by exactly 2^k places. A distance with a single bit set therefore shifts by that power of two.
- R8: The output follows any change of the inputs without a clock edge. No state is held between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 32 | Operand to be shifted |
| shiftAmt | input | 5 | Shift distance, 0 to 31 |
| shiftLeft | input | 1 | 1 = shift toward bit 31, 0 = shift toward bit 0 |
| shiftArith | input | 1 | 1 = sign fill on right shifts, 0 = zero fill |
| dataOut | output | 32 | Shifted result |

## Verification
The assertions are evaluated whenever the inputs settle. They check the following:
- A zero distance passes the operand through unchanged.
- A disabled stage passes its word through unchanged.
- An enabled left stage clears its low bits.
- The top output bit after a nonzero right shift carries the correct fill: zero for logical, the sign for arithmetic.

Only the scoreboard scenarios can show that the complete result is correct bit for bit. The bench sweeps all 32 distances in all direction and fill combinations, over corner and random operands, and compares each result with the language's shift operators. Those sweeps also establish that arithmetic left equals logical left and that the distance bits carry their intended weights.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  // Strobes passed from the control decoder to every shift stage.
  typedef struct packed {
    logic goLeft;   // select the left tap when a stage is enabled
    logic fillBit;  // value entering vacated positions
  } shift_ctrl_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
(
  input  logic        shiftLeft,
  input  logic        shiftArith,
  input  logic        dataMsb,
  output shift_ctrl_t ctrl
);
  always_comb begin
    ctrl.goLeft  = shiftLeft;
    // Sign fill only makes sense moving right; left shifts always fill zero (R5).
    ctrl.fillBit = shiftArith & ~shiftLeft & dataMsb;
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int STEP  = 1
) (
  input  logic [WIDTH-1:0] stageIn,
  input  logic             enable,
  input  shift_ctrl_t      ctrl,
  output logic [WIDTH-1:0] stageOut
);
  logic [WIDTH-1:0] leftTap;
  logic [WIDTH-1:0] rightTap;

  always_comb begin
    leftTap  = {stageIn[WIDTH-1-STEP:0], {STEP{1'b0}}};
    rightTap = {{STEP{ctrl.fillBit}}, stageIn[WIDTH-1:STEP]};
    if (!enable)          stageOut = stageIn;
    else if (ctrl.goLeft) stageOut = leftTap;
    else                  stageOut = rightTap;
  end

  always_comb begin
    // R7: a stage whose distance bit is clear must be transparent
    if (!enable) p_stage_bypass_r7: assert (stageOut == stageIn);
    // R7: an enabled left stage vacates exactly its STEP low bits with zeros
    if (enable && ctrl.goLeft) p_stage_left_fill_r7: assert (stageOut[STEP-1:0] == '0);
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [AMT_W-1:0] shiftAmt,
  input  shift_ctrl_t      ctrl,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] stageVal [0:AMT_W];

  assign stageVal[0] = dataIn;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    shift_stage #(
      .WIDTH (WIDTH),
      .STEP  (1 << k)
    ) u_stage (
      .stageIn  (stageVal[k]),
      .enable   (shiftAmt[k]),
      .ctrl     (ctrl),
      .stageOut (stageVal[k+1])
    );
  end

  assign dataOut = stageVal[AMT_W];

  always_comb begin
    if (shiftAmt == '0) p_zero_amt_pass_r1: assert (dataOut == dataIn);
    if (shiftAmt != '0 && ctrl.goLeft) p_left_low_zero_r2: assert (dataOut[0] == 1'b0);
    if (shiftAmt != '0 && !ctrl.goLeft && !ctrl.fillBit)
      p_right_top_zero_r3: assert (dataOut[WIDTH-1] == 1'b0);
    if (shiftAmt != '0 && !ctrl.goLeft && ctrl.fillBit)
      p_right_top_sign_r4: assert (dataOut[WIDTH-1] == 1'b1);
  end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             shiftLeft,
  input  logic             shiftArith,
  output logic [WIDTH-1:0] dataOut
);
  shift_ctrl_t ctrl;

  shift_ctrl u_ctrl (
    .shiftLeft  (shiftLeft),
    .shiftArith (shiftArith),
    .dataMsb    (dataIn[WIDTH-1]),
    .ctrl       (ctrl)
  );

  shift_datapath #(
    .WIDTH (WIDTH)
  ) u_datapath (
    .dataIn   (dataIn),
    .shiftAmt (shiftAmt),
    .ctrl     (ctrl),
    .dataOut  (dataOut)
  );

  // R5: a left shift never carries the sign into the fill, whatever shiftArith is
  always_comb begin
    if (shiftLeft) p_left_no_sign_fill_r5: assert (ctrl.fillBit == 1'b0);
  end
endmodule

// File: tb/barrel_shifter_tb.sv
module barrel_shifter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dataIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic        shiftLeft = 1'b0;
  logic        shiftArith = 1'b0;
  logic [31:0] dataOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] din;
    int          amt;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;   // 250 MHz

  barrel_shifter u_dut (
    .dataIn     (dataIn),
    .shiftAmt   (shiftAmt),
    .shiftLeft  (shiftLeft),
    .shiftArith (shiftArith),
    .dataOut    (dataOut)
  );

  function automatic logic [31:0] refShift(input logic [31:0] d, input int a,
                                           input bit l, input bit ar);
    logic signed [31:0] sd;
    sd = d;
    if (l)       return d << a;            // R2 / R5
    else if (ar) return 32'(sd >>> a);     // R4
    else         return d >> a;            // R3
  endfunction

  function automatic string pickTag(input int a, input bit l, input bit ar);
    if (a == 0)    return "R1";
    if (a == 31)   return "R6";
    if ((a & (a - 1)) == 0) return "R7";
    if (l && ar)   return "R5";
    if (l)         return "R2";
    if (ar)        return "R4";
    return "R3";
  endfunction

  task automatic drive(input logic [31:0] d, input int a, input bit l, input bit ar,
                       input string tag);
    item_t it;
    @(posedge clk);
    dataIn = d; shiftAmt = 5'(a); shiftLeft = l; shiftArith = ar;
    it.exp = refShift(d, a, l, ar);
    it.din = d; it.amt = a; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: results are sampled at the falling edge, half a cycle after drive
  always @(negedge clk) begin
    if (!rst && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      compared++;
      if (dataOut !== it.exp) begin
        mismatched++;
        $display("FAIL %s din=%h amt=%0d actual=%h expected=%h",
                 it.tag, it.din, it.amt, dataOut, it.exp);
      end
    end
  end

  initial begin
    logic [31:0] pats [0:12];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
    pats[3] = 32'h7FFF_FFFF; pats[4] = 32'h0000_0001; pats[5] = 32'hA5A5_A5A5;
    pats[6] = 32'h5A5A_5A5A;
    for (int j = 7; j < 13; j++) pats[j] = $urandom;

    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state after reset: zero operand, zero distance (R1)
    drive(32'h0, 0, 1'b0, 1'b0, "R1");

    // Full sweep: every distance, every mode, every pattern (R1..R7)
    for (int p = 0; p < 13; p++)
      for (int a = 0; a < 32; a++)
        for (int m = 0; m < 4; m++)
          drive(pats[p], a, m[1], m[0], pickTag(a, m[1], m[0]));

    // R6: maximum distance on a negative operand, right logical vs arithmetic
    drive(32'h8000_0000, 31, 1'b0, 1'b0, "R6");
    drive(32'h8000_0000, 31, 1'b0, 1'b1, "R6");
    // R5: arithmetic left with sign set gives zero fill
    drive(32'hC000_0003, 4, 1'b1, 1'b1, "R5");
    // R8: back-to-back changes with no settling cycle between them
    for (int j = 0; j < 8; j++)
      drive($urandom, j * 3 + 1, j[0], j[1], "R8");

    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule